// File: doc/BRIEF.md
# Virtual-Channel Router for a Linear Chain of Storage Controllers

This block is the packet switch inside one node of a row of storage controllers wired as a straight chain. Each node has three ports: a local port toward its own controller and host, a link toward the node above it, and a link toward the node below it. Traffic travels on several independent virtual channels, one for each kind of storage traffic: commands, read payload, write payload and completions. Every packet is a single word that carries its destination node, its source node and its virtual-channel number. The router sends each packet to its own node or one step up or down the chain. It chooses by comparing the destination with the node's own ID, so the path is fixed and no packet is dropped.

Each output has one queue per virtual channel. A round-robin arbiter picks which channel drives the shared physical link in each cycle. Only a channel whose queue holds data and whose receiver has room takes part in arbitration, so a stalled channel never blocks the others. Local injection uses end-to-end credits. The node keeps one token counter for each destination node and channel. A packet leaves only while its counter is nonzero. Tokens come back through a token-return input. When the local port consumes a packet, the router emits a token addressed to that packet's source.

Top module: `vc_chain_router`

## Requirements
- R1: A packet whose destination equals `my_id` leaves on the local output. A packet injected locally with a larger destination leaves on the up output, and one with a smaller destination leaves on the down output. On the up link, a packet that is not for this node continues down. On the down link, a packet that is not for this node continues up.
- R2: Packet word layout, from most significant bits down: destination (ID_W bits), source (ID_W bits), virtual channel (VC_W bits), payload (DATA_W bits).
- R3: A packet accepted at a clock edge, with no competing traffic, appears on its output in the next cycle.
- R4: Packets of one virtual channel leave each output in the order they were accepted. Packets accepted in the same cycle for the same output and channel are ordered local port first, then up link, then down link.
- R5: An output asserts valid only for a packet whose channel bit in that output's per-channel ready input is high. A channel whose ready is low does not stop other channels on the same output.
- R6: Among eligible channels, the link is granted round-robin in ascending channel order, starting from the channel after the last one granted. After reset, channel 0 has first priority.
- R7: The router loses no packet. A link transfer takes place when valid is high and the ready bit for that packet's channel is high. Every accepted packet eventually leaves once the outputs are ready.
- R8: Local injection is accepted only while the token counter for the packet's (destination, channel) pair is nonzero. Each accepted injection uses one token. Counters start at INIT_TOK after reset.
- R9: A pulse on `tok_in_valid` adds one token to the counter selected by `tok_in_node` and `tok_in_vc`.
- R10: In every cycle where the local output transfers a packet, `tok_out_valid` is high, `tok_out_node` carries that packet's source, and `tok_out_vc` carries its channel.
- R11: After reset, all three outputs are idle, every neighbour-link channel ready is high, and every token counter holds INIT_TOK.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| my_id | input | ID_W | This node's position in the chain |
| loc_in_valid | input | 1 | Local injection valid |
| loc_in_flit | input | FLIT_W | Local injection packet |
| loc_in_ready | output | 1 | Local injection accepted (token and room) |
| up_in_valid | input | 1 | Packet from the node above |
| up_in_flit | input | FLIT_W | Packet word from the node above |
| up_in_vc_rdy | output | VCS | Per-channel room for the node above |
| down_in_valid | input | 1 | Packet from the node below |
| down_in_flit | input | FLIT_W | Packet word from the node below |
| down_in_vc_rdy | output | VCS | Per-channel room for the node below |
| loc_out_valid | output | 1 | Packet delivered to this node |
| loc_out_flit | output | FLIT_W | Delivered packet word |
| loc_out_vc_rdy | input | VCS | Per-channel room at the local consumer |
| up_out_valid | output | 1 | Packet toward the node above |
| up_out_flit | output | FLIT_W | Packet word toward the node above |
| up_out_vc_rdy | input | VCS | Per-channel room at the node above |
| down_out_valid | output | 1 | Packet toward the node below |
| down_out_flit | output | FLIT_W | Packet word toward the node below |
| down_out_vc_rdy | input | VCS | Per-channel room at the node below |
| tok_in_valid | input | 1 | Token returned to this node's injector |
| tok_in_node | input | ID_W | Node that returned the token |
| tok_in_vc | input | VC_W | Channel of the returned token |
| tok_out_valid | output | 1 | Token issued for a consumed local packet |
| tok_out_node | output | ID_W | Source node owed the token |
| tok_out_vc | output | VC_W | Channel of the issued token |

## Verification
A random phase drives all three inputs at once. Destinations are drawn from every legal range, and channel ready bits toggle at random. This mix separates the three routing decisions and checks that each channel keeps its own order when paths merge and when arrivals collide in one cycle. Directed cases cover the following, each in isolation:
- the one-cycle hop latency;
- one blocked channel with another channel passing it;
- the exact round-robin grant order across three loaded channels;
- token exhaustion and refill for a single destination and channel pair.

The token-return input is driven at random against a model count, so any injection made without credit is caught. A final drain shows that no accepted packet was lost.

// File: rtl/vcr_pkg.sv
// Shared definitions for the chain router: output port encoding and the
// direction decision for locally injected packets.
package vcr_pkg;

    typedef enum logic [1:0] {
        OUT_LOCAL = 2'd0,
        OUT_UP    = 2'd1,
        OUT_DOWN  = 2'd2
    } vcr_port_e;

    // Pick the output for a packet from its destination and the node ID.
    function automatic vcr_port_e vcr_pick(input logic [15:0] dst, input logic [15:0] here);
        if (dst == here)     return OUT_LOCAL;
        else if (dst > here) return OUT_UP;
        else                 return OUT_DOWN;
    endfunction

endpackage

// File: rtl/vcr_mwfifo.sv
// Queue with NW write ports and one read port.
// Writes in one cycle are stored in ascending port order.
// Assumes DEPTH is a power of two and that writers push only while room_ok
// is high (room_ok means at least NW free entries).
module vcr_mwfifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4,
    parameter int NW    = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NW-1:0]        push,
    input  logic [NW-1:0][W-1:0] wdata,
    input  logic                 pop,
    output logic [W-1:0]         head,
    output logic                 empty,
    output logic                 room_ok
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = AW + 1;

    logic [W-1:0]           mem [DEPTH];
    logic [AW-1:0]          wptr, rptr;
    logic [CW-1:0]          cnt;
    logic [NW-1:0][AW-1:0]  slot;
    logic [CW-1:0]          npush;

    // Give each active writer the next free slot, in port order.
    always_comb begin
        npush = '0;
        for (int i = 0; i < NW; i++) begin
            slot[i] = wptr + AW'(npush);
            npush   = npush + CW'(push[i]);
        end
    end

    // Store the written words.
    always_ff @(posedge clk) begin
        for (int i = 0; i < NW; i++) begin
            if (push[i]) mem[slot[i]] <= wdata[i];
        end
    end

    // Advance the pointers and the occupancy count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr <= '0;
            rptr <= '0;
            cnt  <= '0;
        end else begin
            wptr <= wptr + AW'(npush);
            rptr <= rptr + AW'(pop);
            cnt  <= cnt + npush - CW'(pop);
        end
    end

    assign head    = mem[rptr];
    assign empty   = (cnt == '0);
    assign room_ok = ((CW'(DEPTH) - cnt) >= CW'(NW));

endmodule

// File: rtl/vcr_rr_arb.sv
// Round-robin arbiter. The search starts at the requester after the last
// grant. After reset, the pointer sits on N-1, so requester 0 goes first.
module vcr_rr_arb #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    input  logic         adv,
    output logic [N-1:0] grant,
    output logic         any
);
    localparam int IW = (N > 1) ? $clog2(N) : 1;

    logic [IW-1:0] last;
    logic [IW-1:0] gidx;

    // Find the first requester after the last grant, wrapping around.
    always_comb begin
        grant = '0;
        any   = 1'b0;
        gidx  = last;
        for (int k = 1; k <= N; k++) begin
            if (!any && req[(int'(last) + k) % N]) begin
                grant[(int'(last) + k) % N] = 1'b1;
                gidx = IW'((int'(last) + k) % N);
                any  = 1'b1;
            end
        end
    end

    // Record the winner when the grant is used.
    always_ff @(posedge clk) begin
        if (!rst_n)          last <= IW'(N - 1);
        else if (adv && any) last <= gidx;
    end

endmodule

// File: rtl/vcr_out_link.sv
// One output port: a queue per virtual channel plus a round-robin pick over
// channels that hold data and whose receiver shows room. A packet shown on
// the output is taken in that cycle, because its channel's ready is high.
module vcr_out_link #(
    parameter int ID_W   = 2,
    parameter int VCS    = 4,
    parameter int DATA_W = 16,
    parameter int DEPTH  = 4,
    parameter int NW     = 2,
    localparam int VC_W  = (VCS > 1) ? $clog2(VCS) : 1,
    localparam int FW    = 2 * ID_W + VC_W + DATA_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NW-1:0]         wr_valid,
    input  logic [NW-1:0][FW-1:0] wr_flit,
    input  logic [VCS-1:0]        link_vc_rdy,
    output logic                  out_valid,
    output logic [FW-1:0]         out_flit,
    output logic [VCS-1:0]        room_ok
);
    logic [VCS-1:0][FW-1:0] heads;
    logic [VCS-1:0]         empty;
    logic [VCS-1:0]         req;
    logic [VCS-1:0]         grant;
    logic                   any;

    for (genvar v = 0; v < VCS; v++) begin : g_vc
        logic [NW-1:0] push_v;

        // Keep only the writes that carry this channel number.
        always_comb begin
            for (int i = 0; i < NW; i++)
                push_v[i] = wr_valid[i] && (wr_flit[i][DATA_W +: VC_W] == VC_W'(v));
        end

        vcr_mwfifo #(.W(FW), .DEPTH(DEPTH), .NW(NW)) q_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .push    (push_v),
            .wdata   (wr_flit),
            .pop     (grant[v]),
            .head    (heads[v]),
            .empty   (empty[v]),
            .room_ok (room_ok[v])
        );

        assign req[v] = !empty[v] && link_vc_rdy[v];
    end

    vcr_rr_arb #(.N(VCS)) arb_i (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (req),
        .adv   (out_valid),
        .grant (grant),
        .any   (any)
    );

    // Drive the head of the granted channel onto the link.
    always_comb begin
        out_flit = '0;
        for (int v = 0; v < VCS; v++)
            if (grant[v]) out_flit = heads[v];
    end

    assign out_valid = any;

endmodule

// File: rtl/vcr_token_bank.sv
// End-to-end credit counters, one per (destination node, channel) pair.
// A counter loses one token per local injection and gains one per returned
// token. Assumes returns never push a counter above INIT_TOK.
module vcr_token_bank #(
    parameter int ID_W     = 2,
    parameter int VCS      = 4,
    parameter int TOK_W    = 3,
    parameter int INIT_TOK = 4,
    localparam int VC_W    = (VCS > 1) ? $clog2(VCS) : 1,
    localparam int NODES   = 1 << ID_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            take,
    input  logic [ID_W-1:0] take_node,
    input  logic [VC_W-1:0] take_vc,
    input  logic            give,
    input  logic [ID_W-1:0] give_node,
    input  logic [VC_W-1:0] give_vc,
    output logic            has_tok
);
    logic [TOK_W-1:0] cnt [NODES][VCS];

    for (genvar n = 0; n < NODES; n++) begin : g_node
        for (genvar v = 0; v < VCS; v++) begin : g_vc
            logic hit_t, hit_g;
            assign hit_t = take && (take_node == ID_W'(n)) && (take_vc == VC_W'(v));
            assign hit_g = give && (give_node == ID_W'(n)) && (give_vc == VC_W'(v));

            // Update the token count for this pair.
            always_ff @(posedge clk) begin
                if (!rst_n) cnt[n][v] <= TOK_W'(INIT_TOK);
                else        cnt[n][v] <= cnt[n][v] + TOK_W'(hit_g) - TOK_W'(hit_t);
            end
        end
    end

    assign has_tok = (cnt[take_node][take_vc] != '0);

endmodule

// File: rtl/vc_chain_router.sv
// Router for one node in a linear chain. Packets move toward their
// destination by comparison with my_id. Each output keeps per-channel
// queues with round-robin link arbitration. Local injection is gated by
// end-to-end tokens. Neighbours must hold a packet until the ready bit for
// its channel is high. A neighbour ready is high only when every queue that
// packet could enter has room.
module vc_chain_router
    import vcr_pkg::*;
#(
    parameter int ID_W     = 2,
    parameter int VCS      = 4,
    parameter int DATA_W   = 16,
    parameter int DEPTH    = 4,
    parameter int TOK_W    = 3,
    parameter int INIT_TOK = 4,
    localparam int VC_W    = (VCS > 1) ? $clog2(VCS) : 1,
    localparam int FLIT_W  = 2 * ID_W + VC_W + DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ID_W-1:0]   my_id,
    input  logic              loc_in_valid,
    input  logic [FLIT_W-1:0] loc_in_flit,
    output logic              loc_in_ready,
    input  logic              up_in_valid,
    input  logic [FLIT_W-1:0] up_in_flit,
    output logic [VCS-1:0]    up_in_vc_rdy,
    input  logic              down_in_valid,
    input  logic [FLIT_W-1:0] down_in_flit,
    output logic [VCS-1:0]    down_in_vc_rdy,
    output logic              loc_out_valid,
    output logic [FLIT_W-1:0] loc_out_flit,
    input  logic [VCS-1:0]    loc_out_vc_rdy,
    output logic              up_out_valid,
    output logic [FLIT_W-1:0] up_out_flit,
    input  logic [VCS-1:0]    up_out_vc_rdy,
    output logic              down_out_valid,
    output logic [FLIT_W-1:0] down_out_flit,
    input  logic [VCS-1:0]    down_out_vc_rdy,
    input  logic              tok_in_valid,
    input  logic [ID_W-1:0]   tok_in_node,
    input  logic [VC_W-1:0]   tok_in_vc,
    output logic              tok_out_valid,
    output logic [ID_W-1:0]   tok_out_node,
    output logic [VC_W-1:0]   tok_out_vc
);
    localparam int VC_LSB  = DATA_W;
    localparam int SRC_LSB = DATA_W + VC_W;
    localparam int DST_LSB = DATA_W + VC_W + ID_W;

    logic [ID_W-1:0] li_dst, ui_dst, di_dst;
    logic [VC_W-1:0] li_vc, ui_vc, di_vc, lo_vc;
    vcr_port_e       li_tgt;
    logic [VCS-1:0]  room_loc, room_up, room_dn;
    logic            tok_ok, li_room;
    logic            li_fire, ui_fire, di_fire;
    logic            ui_to_loc, di_to_loc;

    assign li_dst = loc_in_flit[DST_LSB +: ID_W];
    assign ui_dst = up_in_flit[DST_LSB +: ID_W];
    assign di_dst = down_in_flit[DST_LSB +: ID_W];
    assign li_vc  = loc_in_flit[VC_LSB +: VC_W];
    assign ui_vc  = up_in_flit[VC_LSB +: VC_W];
    assign di_vc  = down_in_flit[VC_LSB +: VC_W];
    assign lo_vc  = loc_out_flit[VC_LSB +: VC_W];
    assign li_tgt = vcr_pick(16'(li_dst), 16'(my_id));

    // Room in the queue that the local injection targets.
    always_comb begin
        case (li_tgt)
            OUT_LOCAL: li_room = room_loc[li_vc];
            OUT_UP:    li_room = room_up[li_vc];
            default:   li_room = room_dn[li_vc];
        endcase
    end

    assign loc_in_ready   = tok_ok && li_room;
    assign up_in_vc_rdy   = room_loc & room_dn;
    assign down_in_vc_rdy = room_loc & room_up;

    assign li_fire   = loc_in_valid && loc_in_ready;
    assign ui_fire   = up_in_valid && up_in_vc_rdy[ui_vc];
    assign di_fire   = down_in_valid && down_in_vc_rdy[di_vc];
    assign ui_to_loc = (ui_dst == my_id);
    assign di_to_loc = (di_dst == my_id);

    vcr_out_link #(.ID_W(ID_W), .VCS(VCS), .DATA_W(DATA_W), .DEPTH(DEPTH), .NW(3)) loc_link_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_valid    ({di_fire && di_to_loc, ui_fire && ui_to_loc, li_fire && (li_tgt == OUT_LOCAL)}),
        .wr_flit     ({down_in_flit, up_in_flit, loc_in_flit}),
        .link_vc_rdy (loc_out_vc_rdy),
        .out_valid   (loc_out_valid),
        .out_flit    (loc_out_flit),
        .room_ok     (room_loc)
    );

    vcr_out_link #(.ID_W(ID_W), .VCS(VCS), .DATA_W(DATA_W), .DEPTH(DEPTH), .NW(2)) up_link_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_valid    ({di_fire && !di_to_loc, li_fire && (li_tgt == OUT_UP)}),
        .wr_flit     ({down_in_flit, loc_in_flit}),
        .link_vc_rdy (up_out_vc_rdy),
        .out_valid   (up_out_valid),
        .out_flit    (up_out_flit),
        .room_ok     (room_up)
    );

    vcr_out_link #(.ID_W(ID_W), .VCS(VCS), .DATA_W(DATA_W), .DEPTH(DEPTH), .NW(2)) down_link_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_valid    ({ui_fire && !ui_to_loc, li_fire && (li_tgt == OUT_DOWN)}),
        .wr_flit     ({up_in_flit, loc_in_flit}),
        .link_vc_rdy (down_out_vc_rdy),
        .out_valid   (down_out_valid),
        .out_flit    (down_out_flit),
        .room_ok     (room_dn)
    );

    vcr_token_bank #(.ID_W(ID_W), .VCS(VCS), .TOK_W(TOK_W), .INIT_TOK(INIT_TOK)) tok_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .take      (li_fire),
        .take_node (li_dst),
        .take_vc   (li_vc),
        .give      (tok_in_valid),
        .give_node (tok_in_node),
        .give_vc   (tok_in_vc),
        .has_tok   (tok_ok)
    );

    assign tok_out_valid = loc_out_valid && loc_out_vc_rdy[lo_vc];
    assign tok_out_node  = loc_out_flit[SRC_LSB +: ID_W];
    assign tok_out_vc    = lo_vc;

endmodule

// File: rtl/vcr_router_chk.sv
// Port-level properties of the chain router, attached by bind.
module vcr_router_chk #(
    parameter int ID_W   = 2,
    parameter int VCS    = 4,
    parameter int DATA_W = 16,
    localparam int VC_W  = (VCS > 1) ? $clog2(VCS) : 1,
    localparam int FW    = 2 * ID_W + VC_W + DATA_W
) (
    input logic            clk,
    input logic            rst_n,
    input logic [ID_W-1:0] my_id,
    input logic            loc_out_valid,
    input logic [FW-1:0]   loc_out_flit,
    input logic [VCS-1:0]  loc_out_vc_rdy,
    input logic            up_out_valid,
    input logic [FW-1:0]   up_out_flit,
    input logic [VCS-1:0]  up_out_vc_rdy,
    input logic            down_out_valid,
    input logic [FW-1:0]   down_out_flit,
    input logic [VCS-1:0]  down_out_vc_rdy
);
    localparam int DL = FW - ID_W;

    AST_LOCAL_DST: assert property (@(posedge clk) disable iff (!rst_n)
        loc_out_valid |-> loc_out_flit[DL +: ID_W] == my_id); // R1
    AST_UP_NOT_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
        up_out_valid |-> up_out_flit[DL +: ID_W] != my_id); // R1
    AST_DOWN_NOT_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
        down_out_valid |-> down_out_flit[DL +: ID_W] != my_id); // R1
    AST_LOC_VC_READY: assert property (@(posedge clk) disable iff (!rst_n)
        loc_out_valid |-> loc_out_vc_rdy[loc_out_flit[DATA_W +: VC_W]]); // R5
    AST_UP_VC_READY: assert property (@(posedge clk) disable iff (!rst_n)
        up_out_valid |-> up_out_vc_rdy[up_out_flit[DATA_W +: VC_W]]); // R5
    AST_DOWN_VC_READY: assert property (@(posedge clk) disable iff (!rst_n)
        down_out_valid |-> down_out_vc_rdy[down_out_flit[DATA_W +: VC_W]]); // R5
    AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !loc_out_valid && !up_out_valid && !down_out_valid); // R11

endmodule

bind vc_chain_router vcr_router_chk #(.ID_W(ID_W), .VCS(VCS), .DATA_W(DATA_W)) chk_i (
    .clk             (clk),
    .rst_n           (rst_n),
    .my_id           (my_id),
    .loc_out_valid   (loc_out_valid),
    .loc_out_flit    (loc_out_flit),
    .loc_out_vc_rdy  (loc_out_vc_rdy),
    .up_out_valid    (up_out_valid),
    .up_out_flit     (up_out_flit),
    .up_out_vc_rdy   (up_out_vc_rdy),
    .down_out_valid  (down_out_valid),
    .down_out_flit   (down_out_flit),
    .down_out_vc_rdy (down_out_vc_rdy)
);

// File: tb/vc_chain_router_tb_top.sv
// Bench for the chain router: directed corner cases plus a seeded random
// phase, checked against a per-output, per-channel scoreboard.
module vc_chain_router_tb_top;
    localparam int ID_W = 2, VCS = 4, DATA_W = 16, DEPTH = 4, TOK_W = 3, INIT_TOK = 4;
    localparam int VC_W = 2, FW = 2 * ID_W + VC_W + DATA_W, MY = 2;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [ID_W-1:0] my_id = ID_W'(MY);
    logic loc_in_valid, up_in_valid, down_in_valid, tok_in_valid;
    logic [FW-1:0] loc_in_flit, up_in_flit, down_in_flit;
    logic loc_in_ready;
    logic [VCS-1:0] up_in_vc_rdy, down_in_vc_rdy;
    logic loc_out_valid, up_out_valid, down_out_valid;
    logic [FW-1:0] loc_out_flit, up_out_flit, down_out_flit;
    logic [VCS-1:0] loc_out_vc_rdy, up_out_vc_rdy, down_out_vc_rdy;
    logic [ID_W-1:0] tok_in_node, tok_out_node;
    logic [VC_W-1:0] tok_in_vc, tok_out_vc;
    logic tok_out_valid;

    always #10 clk = ~clk;

    vc_chain_router #(.ID_W(ID_W), .VCS(VCS), .DATA_W(DATA_W), .DEPTH(DEPTH),
                      .TOK_W(TOK_W), .INIT_TOK(INIT_TOK)) dut_i (.*);

    int checks = 0, fails = 0;
    bit finished = 0;
    int tokm [4][VCS];
    logic [FW-1:0] expq [3][VCS][$];

    function automatic logic [FW-1:0] mk(int dst, int src, int vc, int data);
        return {ID_W'(dst), ID_W'(src), VC_W'(vc), DATA_W'(data)};
    endfunction

    function automatic int route_of(int port, int dst);
        if (dst == MY) return 0;
        if (port == 0) return (dst > MY) ? 1 : 2;
        return (port == 1) ? 2 : 1;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic handle_out(input int o, input logic v, input logic [FW-1:0] f, input logic [VCS-1:0] r);
        int vc;
        logic [FW-1:0] e;
        vc = int'(f[DATA_W +: VC_W]);
        if (!v) return;
        chk(r[vc], "R5 valid only with channel ready", 64'(r), 64'(1 << vc));
        if (!r[vc]) return;
        if (expq[o][vc].size() == 0) begin
            chk(0, "R4 unexpected packet on output", 64'(f), 64'(o));
        end else begin
            e = expq[o][vc].pop_front();
            chk(f == e, "R4 per-channel order and content", 64'(f), 64'(e));
        end
        if (o == 0)
            chk(tok_out_valid && tok_out_node == f[DATA_W + VC_W +: ID_W] && int'(tok_out_vc) == vc,
                "R10 token issued to source", 64'({tok_out_valid, tok_out_node, tok_out_vc}),
                64'({1'b1, f[DATA_W + VC_W +: ID_W], VC_W'(vc)}));
    endtask

    // Score one cycle: outputs first, then accepted inputs, then tokens.
    task automatic observe();
        int d, vc;
        handle_out(0, loc_out_valid, loc_out_flit, loc_out_vc_rdy);
        handle_out(1, up_out_valid, up_out_flit, up_out_vc_rdy);
        handle_out(2, down_out_valid, down_out_flit, down_out_vc_rdy);
        if (loc_in_valid && loc_in_ready) begin
            d = int'(loc_in_flit[FW - ID_W +: ID_W]); vc = int'(loc_in_flit[DATA_W +: VC_W]);
            chk(tokm[d][vc] > 0, "R8 injection only with token", 64'(tokm[d][vc]), 64'(1));
            tokm[d][vc]--;
            expq[route_of(0, d)][vc].push_back(loc_in_flit);
        end
        if (up_in_valid && up_in_vc_rdy[up_in_flit[DATA_W +: VC_W]]) begin
            d = int'(up_in_flit[FW - ID_W +: ID_W]); vc = int'(up_in_flit[DATA_W +: VC_W]);
            expq[route_of(1, d)][vc].push_back(up_in_flit);
        end
        if (down_in_valid && down_in_vc_rdy[down_in_flit[DATA_W +: VC_W]]) begin
            d = int'(down_in_flit[FW - ID_W +: ID_W]); vc = int'(down_in_flit[DATA_W +: VC_W]);
            expq[route_of(2, d)][vc].push_back(down_in_flit);
        end
        if (tok_in_valid) tokm[tok_in_node][tok_in_vc]++;
    endtask

    task automatic fin();
        observe();
        @(negedge clk);
    endtask

    task automatic idle();
        loc_in_valid = 0; up_in_valid = 0; down_in_valid = 0; tok_in_valid = 0;
        loc_in_flit = '0; up_in_flit = '0; down_in_flit = '0;
        tok_in_node = '0; tok_in_vc = '0;
    endtask

    task automatic do_reset();
        idle();
        loc_out_vc_rdy = '1; up_out_vc_rdy = '1; down_out_vc_rdy = '1;
        rst_n = 0;
        repeat (3) @(negedge clk);
        for (int o = 0; o < 3; o++) for (int v = 0; v < VCS; v++) expq[o][v].delete();
        for (int n = 0; n < 4; n++) for (int v = 0; v < VCS; v++) tokm[n][v] = INIT_TOK;
        rst_n = 1;
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    // Inject one local packet, then confirm it on the expected output next cycle.
    task automatic direct_route(input int dst, input int o, input string tag);
        logic [FW-1:0] f;
        f = mk(dst, MY, 2, 16'h1000 + dst);
        loc_in_valid = 1; loc_in_flit = f;
        #1; chk(loc_in_ready, "R8 ready with tokens", 64'(loc_in_ready), 64'(1));
        fin();
        idle();
        #1;
        case (o)
            0: chk(loc_out_valid && loc_out_flit == f, tag, 64'(loc_out_flit), 64'(f));
            1: chk(up_out_valid && up_out_flit == f, tag, 64'(up_out_flit), 64'(f));
            default: chk(down_out_valid && down_out_flit == f, tag, 64'(down_out_flit), 64'(f));
        endcase
        fin();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL R7 watchdog expired act=0 exp=1");
            summary();
        end
    end

    initial begin
        int order [6] = '{0, 1, 2, 0, 1, 2};
        void'($urandom(32'd20240611));
        do_reset();
        #1;
        // R11: idle outputs, open neighbour readies, tokens available
        chk(!loc_out_valid && !up_out_valid && !down_out_valid, "R11 outputs idle after reset",
            64'({loc_out_valid, up_out_valid, down_out_valid}), 64'(0));
        chk(up_in_vc_rdy == '1 && down_in_vc_rdy == '1, "R11 neighbour readies high",
            64'({up_in_vc_rdy, down_in_vc_rdy}), 64'hFF);
        @(negedge clk);

        // R3: one hop of latency, from the up link onward to the down output
        up_in_valid = 1; up_in_flit = mk(1, 3, 1, 16'hA5A5);
        #1; fin();
        idle();
        #1; chk(down_out_valid && down_out_flit == mk(1, 3, 1, 16'hA5A5), "R3 next-cycle delivery",
                64'(down_out_flit), 64'(mk(1, 3, 1, 16'hA5A5)));
        fin();

        // R1 and R2: direction decision, with the header layout built by mk
        direct_route(3, 1, "R1 larger destination goes up (R2 layout)");
        direct_route(0, 2, "R1 smaller destination goes down");
        direct_route(MY, 0, "R1 own destination delivered locally");

        // R5: channel 0 blocked at the local consumer, channel 1 passes
        loc_out_vc_rdy = 4'b1110;
        up_in_valid = 1; up_in_flit = mk(MY, 3, 0, 16'h0C00);
        #1; fin();
        up_in_flit = mk(MY, 3, 1, 16'h0C01);
        #1; chk(!loc_out_valid, "R5 blocked channel holds output", 64'(loc_out_valid), 64'(0));
        fin();
        idle();
        #1; chk(loc_out_valid && loc_out_flit[DATA_W +: VC_W] == 1, "R5 other channel passes",
                64'(loc_out_flit[DATA_W +: VC_W]), 64'(1));
        fin();
        loc_out_vc_rdy = '1;
        #1; chk(loc_out_valid && loc_out_flit[DATA_W +: VC_W] == 0, "R5 blocked channel released",
                64'(loc_out_flit[DATA_W +: VC_W]), 64'(0));
        fin();

        // R8 and R9: drain the tokens for (node 0, channel 3), then return one
        for (int k = 0; k < INIT_TOK; k++) begin
            loc_in_valid = 1; loc_in_flit = mk(0, MY, 3, k);
            #1; chk(loc_in_ready, "R8 token still available", 64'(loc_in_ready), 64'(1));
            fin();
        end
        loc_in_flit = mk(0, MY, 3, 16'hEE);
        #1; chk(!loc_in_ready, "R8 no token blocks injection", 64'(loc_in_ready), 64'(0));
        fin();
        idle();
        tok_in_valid = 1; tok_in_node = 0; tok_in_vc = 3;
        #1; fin();
        idle();
        loc_in_valid = 1; loc_in_flit = mk(0, MY, 3, 16'hEF);
        #1; chk(loc_in_ready, "R9 returned token re-enables injection", 64'(loc_in_ready), 64'(1));
        fin();
        idle();
        repeat (4) begin #1; fin(); end

        // R6: load channels 0,1,2 toward down while blocked, then release
        do_reset();
        down_out_vc_rdy = '0;
        for (int k = 0; k < 6; k++) begin
            loc_in_valid = 1; loc_in_flit = mk(0, MY, k / 2, 16'h600 + k);
            #1; fin();
        end
        idle();
        down_out_vc_rdy = '1;
        for (int k = 0; k < 6; k++) begin
            #1; chk(down_out_valid && int'(down_out_flit[DATA_W +: VC_W]) == order[k],
                    "R6 round-robin grant order", 64'(down_out_flit[DATA_W +: VC_W]), 64'(order[k]));
            fin();
        end

        // Random phase: all inputs together, random readies and token returns
        for (int c = 0; c < 4000; c++) begin
            int vc, n;
            loc_out_vc_rdy = VCS'($urandom); up_out_vc_rdy = VCS'($urandom | $urandom);
            down_out_vc_rdy = VCS'($urandom | $urandom);
            loc_in_valid = ($urandom % 3) != 0;
            loc_in_flit = mk($urandom % 4, MY, $urandom % VCS, $urandom);
            vc = $urandom % VCS;
            up_in_flit = mk($urandom % 3, 3, vc, $urandom);
            up_in_valid = ($urandom % 2 == 0) && up_in_vc_rdy[vc];
            vc = $urandom % VCS;
            down_in_flit = mk(2 + $urandom % 2, $urandom % 2, vc, $urandom);
            down_in_valid = ($urandom % 2 == 0) && down_in_vc_rdy[vc];
            n = $urandom % 4; vc = $urandom % VCS;
            tok_in_node = ID_W'(n); tok_in_vc = VC_W'(vc);
            tok_in_valid = (tokm[n][vc] < INIT_TOK) && ($urandom % 2 == 0);
            #1; fin();
        end

        // R7: drain and confirm every accepted packet came out
        idle();
        loc_out_vc_rdy = '1; up_out_vc_rdy = '1; down_out_vc_rdy = '1;
        repeat (40) begin #1; fin(); end
        for (int o = 0; o < 3; o++)
            for (int v = 0; v < VCS; v++)
                chk(expq[o][v].size() == 0, "R7 no packet lost", 64'(expq[o][v].size()), 64'(0));

        finished = 1;
        summary();
    end

endmodule